// File: doc/BRIEF.md
# Dual Wiper Position Control Register

This block keeps the wiper positions of two independent digital potentiometer channels. Channel A has 100 taps and channel B has 256 taps. Each channel has a volatile wiper register that drives the resistor switches and a companion nonvolatile register that holds a saved position. Here the nonvolatile register is a plain flop. Each wiper register is decoded into a one-hot tap-select vector, so exactly one switch per channel is closed. That vector covers both array ends and every node between segments.

After reset each wiper sits at a preset position: channel A at its low end and channel B at its high end. A fixed number of clock cycles later, both wipers are loaded from their nonvolatile registers and a recall-done flag goes high. From then on, a host command decoder can do four things on one channel at a time: write a wiper, read it back, save it into the nonvolatile register, or reload it from the nonvolatile register.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: `tap_sel_a` has 100 bits and `tap_sel_b` has 256 bits. Bit k of a channel's vector is set exactly when that channel's wiper is at tap k, and all other bits are clear.
- R2: These values hold while `rst` is high, and afterwards until `recall_done` rises:
  - channel A sits at tap 0;
  - channel B sits at tap 255;
  - `recall_done` is low.
- R3: Count the rising clock edges at which `rst` is sampled low. On the RECALL_CYCLES-th such edge (default 4):
  - `recall_done` goes high;
  - each wiper takes the value of its nonvolatile register.
  `recall_done` then stays high until the next reset.
- R4: Reset sets the nonvolatile registers to their initial contents: 50 for channel A and 128 for channel B.
- R5: While `recall_done` is low, every command is ignored. No wiper changes and `rd_valid` stays low.
- R6: A write command loads the selected wiper from `cmd_wdata`. For channel A, any value above 99 is stored as 99.
- R7: After a read command, on the next clock `rd_valid` is high for one cycle and `rd_data` holds the selected wiper, zero-extended.
- R8: A store command copies the selected wiper into its nonvolatile register, without moving the wiper.
- R9: A recall command reloads the selected wiper from its nonvolatile register.
- R10: A command acts only in a cycle where `cmd_valid` is high. `cmd_chan` selects the channel: 0 is A, 1 is B. `cmd_op` is decoded as:
  - 0: no-op;
  - 1: write;
  - 2: read;
  - 3: store;
  - 4: recall;
  - 5 to 7: no-op.
- R11: After reset, each tap-select vector has exactly one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_chan | input | 1 | Channel select (0 = A, 1 = B) |
| cmd_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response data |
| recall_done | output | 1 | Power-up recall finished |
| tap_sel_a | output | 100 | One-hot tap select, channel A |
| tap_sel_b | output | 256 | One-hot tap select, channel B |

## Verification
The hardest window to reach is the recall interval between reset release and `recall_done`. The wipers must hold their presets there, and commands must be dropped. The bench keeps a write command asserted through the whole interval. It checks the presets at every edge, then checks that the recalled values, not the written ones, appear on the edge where recall completes. A full sweep of all 256 write values on both channels covers the clamp boundary at 99/100 and every one-hot position.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WRITE  = 3'd1,
        OP_READ   = 3'd2,
        OP_STORE  = 3'd3,
        OP_RECALL = 3'd4
    } wiper_op_e;

    typedef struct packed {
        logic              valid;
        wiper_op_e         op;
        logic              chan;
        logic [DATA_W-1:0] data;
    } wiper_cmd_t;

    function automatic logic [DATA_W-1:0] clamp_tap(input logic [DATA_W-1:0] v,
                                                    input logic [DATA_W-1:0] top);
        return (v > top) ? top : v;
    endfunction

endpackage

// File: rtl/tap_decoder.sv
module tap_decoder #(
    parameter int unsigned TAPS = 100,
    localparam int unsigned W = $clog2(TAPS)
) (
    input  logic [W-1:0]    pos,
    output logic [TAPS-1:0] sel
);
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign sel[i] = (pos == W'(i));
    end
endmodule

// File: rtl/recall_seq.sv
module recall_seq #(
    parameter int unsigned CYCLES = 4,
    localparam int unsigned CW = $clog2(CYCLES) + 1
) (
    input  logic clk,
    input  logic rst,
    output logic recall_pulse,
    output logic recall_done
);
    logic [CW-1:0] cnt_q;
    logic          done_q;

    assign recall_pulse = !done_q && (cnt_q == CW'(CYCLES - 1));
    assign recall_done  = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (recall_pulse) done_q <= 1'b1;
        end
    end

    // R3
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q);

    // R3
    pulse_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
        recall_pulse |=> (done_q && !recall_pulse));
endmodule

// File: rtl/wiper_channel.sv
module wiper_channel
    import wiper_pkg::*;
#(
    parameter int unsigned TAPS    = 100,
    parameter int unsigned PRESET  = 0,
    parameter int unsigned NV_INIT = 50,
    localparam int unsigned W = $clog2(TAPS),
    localparam logic [DATA_W-1:0] TOP = DATA_W'(TAPS - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              recall_pulse,
    input  logic              recall_done,
    input  logic              sel,
    input  logic              cmd_valid,
    input  wiper_op_e         cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic [W-1:0]      wiper_o,
    output logic [TAPS-1:0]   tap_sel_o
);
    logic [W-1:0] wcr_q;
    logic [W-1:0] nvm_q;
    logic         act;
    logic [W-1:0] wr_val;

    assign act    = recall_done && sel && cmd_valid;
    assign wr_val = W'(clamp_tap(cmd_data, TOP));

    always_ff @(posedge clk) begin
        if (rst) begin
            wcr_q <= W'(PRESET);
        end else if (recall_pulse) begin
            wcr_q <= nvm_q;
        end else if (act) begin
            case (cmd_op)
                OP_WRITE:  wcr_q <= wr_val;
                OP_RECALL: wcr_q <= nvm_q;
                default:   wcr_q <= wcr_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nvm_q <= W'(NV_INIT);
        end else if (act && cmd_op == OP_STORE) begin
            nvm_q <= wcr_q;
        end
    end

    tap_decoder #(.TAPS(TAPS)) dec_i (
        .pos (wcr_q),
        .sel (tap_sel_o)
    );

    assign wiper_o = wcr_q;

    // R11
    onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel_o) == 1);

    // R2
    preset_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !recall_done |-> (wcr_q == W'(PRESET)));

    // R6
    in_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(wcr_q) <= int'(TAPS - 1));

    // R6
    write_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (act && cmd_op == OP_WRITE) |=>
            ((int'(wcr_q) == int'($past(cmd_data))) ||
             (int'($past(cmd_data)) > int'(TAPS - 1) && int'(wcr_q) == int'(TAPS - 1))));

    // R8
    store_chk: assert property (@(posedge clk) disable iff (rst)
        (act && cmd_op == OP_STORE) |=> (nvm_q == $past(wcr_q) && $stable(wcr_q)));

    // R3
    recall_load_chk: assert property (@(posedge clk) disable iff (rst)
        recall_pulse |=> (wcr_q == $past(nvm_q)));
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int unsigned TAPS_A        = 100,
    parameter int unsigned TAPS_B        = 256,
    parameter int unsigned NV_INIT_A     = 50,
    parameter int unsigned NV_INIT_B     = 128,
    parameter int unsigned RECALL_CYCLES = 4,
    localparam int unsigned WA = $clog2(TAPS_A),
    localparam int unsigned WB = $clog2(TAPS_B)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_chan,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              recall_done,
    output logic [TAPS_A-1:0] tap_sel_a,
    output logic [TAPS_B-1:0] tap_sel_b
);
    wiper_cmd_t        cmd_s;
    logic              recall_pulse;
    logic [WA-1:0]     wiper_a;
    logic [WB-1:0]     wiper_b;
    logic              rd_req;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;

    assign cmd_s.valid = cmd_valid;
    assign cmd_s.op    = wiper_op_e'(cmd_op);
    assign cmd_s.chan  = cmd_chan;
    assign cmd_s.data  = cmd_wdata;

    recall_seq #(.CYCLES(RECALL_CYCLES)) seq_i (
        .clk          (clk),
        .rst          (rst),
        .recall_pulse (recall_pulse),
        .recall_done  (recall_done)
    );

    wiper_channel #(.TAPS(TAPS_A), .PRESET(0), .NV_INIT(NV_INIT_A)) chan_a_i (
        .clk          (clk),
        .rst          (rst),
        .recall_pulse (recall_pulse),
        .recall_done  (recall_done),
        .sel          (!cmd_s.chan),
        .cmd_valid    (cmd_s.valid),
        .cmd_op       (cmd_s.op),
        .cmd_data     (cmd_s.data),
        .wiper_o      (wiper_a),
        .tap_sel_o    (tap_sel_a)
    );

    wiper_channel #(.TAPS(TAPS_B), .PRESET(TAPS_B - 1), .NV_INIT(NV_INIT_B)) chan_b_i (
        .clk          (clk),
        .rst          (rst),
        .recall_pulse (recall_pulse),
        .recall_done  (recall_done),
        .sel          (cmd_s.chan),
        .cmd_valid    (cmd_s.valid),
        .cmd_op       (cmd_s.op),
        .cmd_data     (cmd_s.data),
        .wiper_o      (wiper_b),
        .tap_sel_o    (tap_sel_b)
    );

    assign rd_req = recall_done && cmd_s.valid && (cmd_s.op == OP_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= rd_req;
            if (rd_req) rd_data_q <= cmd_s.chan ? DATA_W'(wiper_b) : DATA_W'(wiper_a);
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    // R7
    read_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid_q);

    // R5
    idle_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        !recall_done |=> !rd_valid_q);

    // R3
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(recall_done) |-> (int'(wiper_a) == int'($past(chan_a_i.nvm_q))));
endmodule

// File: tb/dual_wiper_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_wiper_ctrl_tb_top;
    localparam int TA  = 100;
    localparam int TB  = 256;
    localparam int RC  = 4;
    localparam int NVA = 50;
    localparam int NVB = 128;

    logic           clk = 1'b0;
    logic           rst;
    logic           cmd_valid;
    logic [2:0]     cmd_op;
    logic           cmd_chan;
    logic [7:0]     cmd_wdata;
    logic           rd_valid;
    logic [7:0]     rd_data;
    logic           recall_done;
    logic [TA-1:0]  tap_sel_a;
    logic [TB-1:0]  tap_sel_b;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dual_wiper_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_chan    (cmd_chan),
        .cmd_wdata   (cmd_wdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .recall_done (recall_done),
        .tap_sel_a   (tap_sel_a),
        .tap_sel_b   (tap_sel_b)
    );

    function automatic logic [255:0] onehot(input int idx);
        logic [255:0] v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic int clamp_a(input int v);
        return (v > TA - 1) ? TA - 1 : v;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_taps(input string req, input int ea, input int eb);
        chk(req, "tap_sel_a", 256'(tap_sel_a), onehot(ea));
        chk(req, "tap_sel_b", 256'(tap_sel_b), onehot(eb));
    endtask

    task automatic issue(input logic [2:0] op, input logic ch, input int data);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_chan  = ch;
        cmd_wdata = 8'(data);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic read_chk(input string req, input logic ch, input int exp);
        issue(3'd2, ch, 0);
        chk(req, "rd_valid", 256'(rd_valid), 256'(1));
        chk(req, "rd_data", 256'(rd_data), 256'(exp));
        @(posedge clk);
        @(negedge clk);
        chk(req, "rd_valid drop", 256'(rd_valid), 256'(0));
    endtask

    // Reset, then walk the recall window with a write held on channel A.
    task automatic do_reset();
        rst       = 1'b1;
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
        cmd_chan  = 1'b0;
        cmd_wdata = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 preset while in reset
        chk_taps("R2", 0, TB - 1);
        chk("R2", "recall_done", 256'(recall_done), 256'(0));
        rst       = 1'b0;
        // R5: write pending throughout recall window
        cmd_valid = 1'b1;
        cmd_op    = 3'd1;
        cmd_wdata = 8'd9;
        for (int k = 1; k <= RC; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k < RC) begin
                chk("R2", "recall_done", 256'(recall_done), 256'(0));
                chk_taps("R5", 0, TB - 1);
                chk("R5", "rd_valid", 256'(rd_valid), 256'(0));
            end else begin
                chk("R3", "recall_done", 256'(recall_done), 256'(1));
                // R4 initial nonvolatile contents recalled
                chk_taps("R4", NVA, NVB);
            end
        end
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    initial begin
        do_reset();
        // R3 recall_done stays high
        @(posedge clk);
        @(negedge clk);
        chk("R3", "recall_done held", 256'(recall_done), 256'(1));
        read_chk("R7", 1'b0, NVA);
        read_chk("R7", 1'b1, NVB);

        // R1 R6 R11: sweep channel A writes
        for (int v = 0; v < 256; v++) begin
            issue(3'd1, 1'b0, v);
            chk_taps("R6", clamp_a(v), NVB);
            n_cmp++;
            if ($countones(tap_sel_a) != 1) begin
                n_bad++;
                $display("FAIL R11 onehot A: actual %0d expected 1", $countones(tap_sel_a));
            end
            read_chk("R1", 1'b0, clamp_a(v));
        end
        // sweep channel B writes
        for (int v = 0; v < 256; v++) begin
            issue(3'd1, 1'b1, v);
            chk_taps("R1", TA - 1, v);
            read_chk("R7", 1'b1, v);
        end

        // R8 R9: store then recall
        issue(3'd1, 1'b0, 77);
        issue(3'd3, 1'b0, 0);
        chk_taps("R8", 77, TB - 1);
        issue(3'd1, 1'b0, 3);
        chk_taps("R6", 3, TB - 1);
        issue(3'd4, 1'b0, 0);
        chk_taps("R9", 77, TB - 1);
        // channel B nonvolatile untouched by A store: still NVB
        issue(3'd4, 1'b1, 0);
        chk_taps("R9", 77, NVB);
        issue(3'd1, 1'b1, 200);
        issue(3'd3, 1'b1, 0);
        issue(3'd1, 1'b1, 5);
        issue(3'd4, 1'b1, 0);
        chk_taps("R8", 77, 200);

        // R10: unused opcodes and cmd_valid low have no effect
        issue(3'd1, 1'b0, 10);
        for (int op = 5; op < 8; op++) begin
            issue(3'(op), 1'b0, 20);
            chk_taps("R10", 10, 200);
            chk("R10", "rd_valid", 256'(rd_valid), 256'(0));
        end
        issue(3'd0, 1'b1, 20);
        chk_taps("R10", 10, 200);
        cmd_op = 3'd1; cmd_chan = 1'b0; cmd_wdata = 8'd30; cmd_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_taps("R10", 10, 200);

        // R4: reset restores initial nonvolatile contents
        do_reset();
        read_chk("R4", 1'b1, NVB);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule